// File: doc/BRIEF.md
# Two-Stage Clock Divider Setting Solver

This block works out how a clock branch should divide one source clock to reach a requested rate without going above it. It is given a source rate, a requested rate (both 32-bit unsigned, in any common unit) and a 2-bit source selector. It returns two field codes: one for a pre-divider with ratios 1 to 32, and one for a post-divider with ratios 1 to 4. It also returns the rate those settings really produce.

Source 3 is the only source with the pre-divider in its path. For that source, a total division larger than 4 is split across both stages using fixed bands. Every other source uses the post-divider alone.

A single pulse on `start` launches one computation while the block is idle. All the work runs through one shared 32-step restoring divider, which is used three times in turn: once for the total division, once for the pre-divider ratio, and once for the achieved rate. `done` then pulses for one cycle, and the result outputs hold their values until the next accepted start.

Top module: `rate_split_solver`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `sat` are 0, `pre_code` and `post_code` are 0, and `out_rate` is 0.
- R2: When `src_rate` is nonzero and `req_rate` is larger than it, the request is treated as equal to `src_rate`. This gives a total of 1, both codes 0, and `out_rate` equal to `src_rate`.
- R3: The total division is the ceiling of `src_rate` divided by the (clamped) request, with a floor of 1. A zero source therefore gives a total of 1 and an `out_rate` of 0.
- R4: When `src_sel` is not 3, or the total is 4 or less, the pre-divide ratio is 1 and the post-divide ratio equals the total. Every code is its ratio minus one: `pre_code` holds pre-ratio−1 in 5 bits, and `post_code` holds post-ratio−1 in 2 bits.
- R5: With `src_sel` = 3 and a total from 5 to 31, the pre ratio is the total and the post ratio is 1.
- R6: With `src_sel` = 3 and a total from 32 to 63, the post ratio is 2 and the pre ratio is ceil(total/2).
- R7: With `src_sel` = 3, a total from 64 to 95 gives post ratio 3 and pre ratio ceil(total/3). A total of 96 or more gives post ratio 4 and pre ratio ceil(total/4).
- R8: A pre ratio that would exceed 32 is limited to 32 (code 31), and `sat` is raised. A non-split total above 4 limits the post ratio to 4 (code 3), and `sat` is raised.
- R9: `out_rate` is floor(floor(`src_rate`/pre)/post), using the ratios that were actually output. When `sat` is 0, it never exceeds `req_rate`.
- R10: A start with `req_rate` = 0 raises `err` with `done` on the next cycle. In that case both codes, `out_rate` and `sat` are 0, and `busy` never rises.
- R11: An accepted start with a nonzero request raises `busy` on the next cycle. `done` then pulses for exactly one cycle, 96 clock edges after the accepting edge. Starts seen while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a computation when the block is idle |
| src_rate | input | 32 | Source clock rate |
| req_rate | input | 32 | Requested output rate |
| src_sel | input | 2 | Source index; 3 enables the pre-divider split |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Last request was zero |
| sat | output | 1 | A ratio was limited to its field range |
| pre_code | output | 5 | Pre-divider ratio minus one |
| post_code | output | 2 | Post-divider ratio minus one |
| out_rate | output | 32 | Rate achieved with the returned settings |

## Verification
The bench steps the total through every value from 1 to 130, using a request of 1 and the source rate equal to the total. This is done both with source 3 and with another source. It hits every band edge (4/5, 31/32, 63/64, 95/96) and the point where the pre ratio saturates, and it shows that the split is tied to source 3 alone.

A second sweep holds the source at 1000 and walks the request from 1 to 200. It probes the ceiling rounding with non-exact quotients, and it checks that the achieved rate stays at or below the request.

Directed cases cover the following:
- a request above the source (clamping);
- a zero source and a zero request;
- the largest source with a request of 1;
- a start that arrives while the block is busy, whose result must match the undisturbed computation.

// File: rtl/rate_split_solver.sv
module rate_split_solver (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] src_rate,
  input  logic [31:0] req_rate,
  input  logic [1:0]  src_sel,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        sat,
  output logic [4:0]  pre_code,
  output logic [1:0]  post_code,
  output logic [31:0] out_rate
);
  logic        run, spl, done_q, err_q, sat_q;
  logic [1:0]  ph, sel_q, post_c, post_sel;
  logic [4:0]  cnt, pre_c, pre_nx;
  logic [31:0] quo, rem, dvs, src_q, rate_q;

  wire [32:0] sh     = {rem, quo[31]};
  wire [32:0] dif    = sh - {1'b0, dvs};
  wire        take   = ~dif[32];
  wire [31:0] quo_n  = {quo[30:0], take};
  wire [31:0] rem_n  = take ? dif[31:0] : sh[31:0];
  wire [31:0] ceil_q = quo_n + {31'd0, |rem_n};
  wire [31:0] tot    = (ceil_q == 32'd0) ? 32'd1 : ceil_q;
  wire        split  = (sel_q == 2'd3) && (tot > 32'd4);
  wire [31:0] clamp  = (src_rate != 32'd0 && req_rate > src_rate) ? src_rate : req_rate;
  wire [7:0]  prod   = ({3'd0, pre_nx} + 8'd1) * ({6'd0, post_c} + 8'd1);

  always_comb begin
    if (!split)                post_sel = (tot > 32'd4) ? 2'd3 : tot[1:0] - 2'd1;
    else if (tot < 32'd32)     post_sel = 2'd0;
    else if (tot < 32'd64)     post_sel = 2'd1;
    else if (tot < 32'd96)     post_sel = 2'd2;
    else                       post_sel = 2'd3;
  end

  always_comb begin
    if (!spl)                  pre_nx = 5'd0;
    else if (ceil_q > 32'd32)  pre_nx = 5'd31;
    else                       pre_nx = ceil_q[4:0] - 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; spl <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; sat_q <= 1'b0;
      ph <= 2'd0; sel_q <= 2'd0; post_c <= 2'd0; cnt <= 5'd0; pre_c <= 5'd0;
      quo <= 32'd0; rem <= 32'd0; dvs <= 32'd1; src_q <= 32'd0; rate_q <= 32'd0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          src_q <= src_rate; sel_q <= src_sel; sat_q <= 1'b0;
          pre_c <= 5'd0; post_c <= 2'd0; rate_q <= 32'd0;
          if (req_rate == 32'd0) begin
            err_q <= 1'b1; done_q <= 1'b1;
          end else begin
            err_q <= 1'b0; run <= 1'b1; ph <= 2'd0; cnt <= 5'd0;
            quo <= src_rate; rem <= 32'd0; dvs <= clamp;
          end
        end
      end else begin
        cnt <= cnt + 5'd1;
        quo <= quo_n;
        rem <= rem_n;
        if (cnt == 5'd31) begin
          rem <= 32'd0;
          case (ph)
            2'd0: begin
              spl    <= split;
              post_c <= post_sel;
              sat_q  <= !split && (tot > 32'd4);
              quo    <= tot;
              dvs    <= {30'd0, post_sel} + 32'd1;
              ph     <= 2'd1;
            end
            2'd1: begin
              pre_c <= pre_nx;
              if (spl && ceil_q > 32'd32) sat_q <= 1'b1;
              quo   <= src_q;
              dvs   <= {24'd0, prod};
              ph    <= 2'd2;
            end
            default: begin
              rate_q <= quo_n;
              run    <= 1'b0;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign busy      = run;
  assign done      = done_q;
  assign err       = err_q;
  assign sat       = sat_q;
  assign pre_code  = pre_c;
  assign post_code = post_c;
  assign out_rate  = rate_q;
endmodule

module rate_split_solver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] req_rate,
  input logic [1:0]  src_sel,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        sat,
  input logic [4:0]  pre_code,
  input logic [1:0]  post_code,
  input logic [31:0] out_rate
);
  logic [31:0] req_cap;
  logic [1:0]  sel_cap;
  logic [7:0]  lat;
  wire accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cap <= 32'd0; sel_cap <= 2'd0; lat <= 8'd0;
    end else if (accept) begin
      req_cap <= req_rate; sel_cap <= src_sel; lat <= 8'd1;
    end else if (busy) begin
      lat <= lat + 8'd1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> lat == 8'd97); // R11
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_rate != 32'd0 |=> busy); // R11
  AST_ZERO_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_rate == 32'd0 |=> done && err && !busy); // R10
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> pre_code == 5'd0 && post_code == 2'd0 && out_rate == 32'd0 && !sat); // R10
  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && !sat |-> out_rate <= req_cap); // R9
  AST_NO_SPLIT_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && sel_cap != 2'd3 |-> pre_code == 5'd0); // R4
endmodule

bind rate_split_solver rate_split_solver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate), .src_sel(src_sel),
  .busy(busy), .done(done), .err(err), .sat(sat), .pre_code(pre_code),
  .post_code(post_code), .out_rate(out_rate)
);

// File: tb/tb_rate_split_solver.sv
`timescale 1ns/1ps
module tb_rate_split_solver;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] src_rate = 32'd0, req_rate = 32'd0;
  logic [1:0]  src_sel = 2'd0;
  logic busy, done, err, sat;
  logic [4:0]  pre_code;
  logic [1:0]  post_code;
  logic [31:0] out_rate;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rate_split_solver dut (.*);

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] s, input logic [31:0] r, input logic [1:0] k,
      output bit e, output bit sa, output logic [4:0] pc, output logic [1:0] qc,
      output logic [31:0] rt, output string tag);
    longint ls = s, lr = r, t, pre, post;
    e = 0; sa = 0; pc = 0; qc = 0; rt = 0;
    if (r == 0) begin e = 1; tag = "R10"; return; end
    if (ls != 0 && lr > ls) lr = ls;
    t = (ls + lr - 1) / lr;
    if (t == 0) t = 1;
    pre = 1; post = t; tag = "R4";
    if (k == 2'd3 && t > 4) begin
      if (t < 32)      begin pre = t; post = 1; tag = "R5"; end
      else if (t < 64) begin post = 2; pre = (t + 1) / 2; tag = "R6"; end
      else if (t < 96) begin post = 3; pre = (t + 2) / 3; tag = "R7"; end
      else             begin post = 4; pre = (t + 3) / 4; tag = "R7"; end
      if (pre > 32) begin pre = 32; sa = 1; tag = "R8"; end
    end else if (t > 4) begin
      post = 4; sa = 1; tag = "R8";
    end
    rt = 32'((ls / pre) / post);
    pc = 5'(pre - 1);
    qc = 2'(post - 1);
  endfunction

  task automatic run_op(input logic [31:0] s, input logic [31:0] r, input logic [1:0] k,
                        input string force_tag, input bit disturb);
    bit e, sa; logic [4:0] pc; logic [1:0] qc; logic [31:0] rt; string tag; int n;
    model(s, r, k, e, sa, pc, qc, rt, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    src_rate = s; req_rate = r; src_sel = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      if (disturb && n == 10) begin
        src_rate = 32'd7; req_rate = 32'd0; src_sel = 2'd1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done == 1'b1, "R11", "done seen", longint'(done), 1);
    check(n == (e ? 0 : 96), "R11", "latency", n, e ? 0 : 96);
    check(err == e && sat == sa && pre_code == pc && post_code == qc, tag,
          $sformatf("codes src=%0d req=%0d sel=%0d {err,sat,pre,post}", s, r, k),
          {err, sat, pre_code, post_code}, {e, sa, pc, qc});
    check(out_rate == rt, e ? "R10" : "R9", $sformatf("rate src=%0d req=%0d", s, r), out_rate, rt);
    @(negedge clk);
    check(!done, "R11", "done single cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !sat && pre_code == 0 && post_code == 0 && out_rate == 0,
          "R1", "reset state", {busy, done, err, sat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 1; t <= 130; t++) begin
      run_op(32'(t), 32'd1, 2'd3, "", 1'b0);
      run_op(32'(t), 32'd1, 2'd0, "", 1'b0);
    end
    for (int r = 1; r <= 200; r++) run_op(32'd1000, 32'(r), 2'd3, "R3", 1'b0);
    for (int r = 1; r <= 10; r++)  run_op(32'd997, 32'(r), 2'd1, "R3", 1'b0);
    run_op(32'd100, 32'd500, 2'd3, "R2", 1'b0);
    run_op(32'd100, 32'd500, 2'd2, "R2", 1'b0);
    run_op(32'd0, 32'd5, 2'd3, "R3", 1'b0);
    run_op(32'd1000, 32'd0, 2'd3, "R10", 1'b0);
    run_op(32'hFFFF_FFFF, 32'd1, 2'd3, "R8", 1'b0);
    run_op(32'd4000, 32'd77, 2'd3, "R11", 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule